// File: doc/BRIEF.md
# Four-Buffer Trace Ring DMA Writer

This block takes a stream of captured 32-bit trace words and turns it into write requests toward memory, filling four equally sized buffers one after another in a ring. Each buffer has its own 64-bit base address. A single shared size register sets how many bytes each buffer holds. The buffers fill in the order 0, 1, 2, 3 and then wrap back to 0. When a buffer becomes full, its completion flag in an interrupt status register is raised and writing moves on to the next buffer.

Software drives the block through a small 32-bit register bus. Before tracing it polls an idle flag. It then pulses a DMA reset that returns the buffer index and byte count to zero, and finally sets the enable bit. A write-status register shows where the writer currently is. If software has not yet cleared a buffer's completion flag when that buffer comes round to be refilled, the block does not overwrite the buffer. Instead it discards the incoming words and records a sticky overflow flag.

Top module: `trace_ring_writer`

## Requirements
- R1: After reset the write port is quiet, the interrupt is low, 0x8B0 reads 1 (idle), 0x8A0 reads 0, the mask at 0x894 reads 0xF, and the size register at 0x800 holds the default size parameter.
- R2: The size register (0x800, bits 27:0, in bytes) and the per-buffer base registers read back what was written. Buffer i has its low word at 0x810+8*i and its high word at 0x814+8*i.
- R3: Each trace word is written to base[idx] plus the byte count. The byte count grows by 4 for each completed write. 0x8A0 reports the byte count in bits 27:0 and the buffer index in bits 29:28.
- R4: When the byte count reaches the buffer size, bit idx of 0x890 is set and the index advances. The index moves 0, 1, 2, 3 and then back to 0, and the count restarts at 0.
- R5: Writing 1 to a bit of 0x890 clears that bit, and writing 0 to a bit leaves it unchanged. If a completion and a clear hit the same bit in the same cycle, the completion wins.
- R6: The irq output is the OR of the status bits whose mask bit at 0x894 is 0. A mask bit of 1 hides its status bit, and the mask resets to all ones.
- R7: If a word is accepted at byte count 0 while the status bit of the current buffer is still set, no write is issued and the index and count stay where they are. The sticky overflow flag in bit 1 of 0x8B0 is set.
- R8: An issued write request keeps wr_valid, wr_addr and wr_data steady until wr_ready is seen. While a request is outstanding, tr_ready is low.
- R9: 0x850 bit 0 enables tracing and bit 1 requests a DMA reset. While the reset bit is set, tr_ready is low. Once no write is outstanding, the index, the count and the overflow flag are cleared, so 0x8A0 reads 0.
- R10: Bit 0 of 0x8B0 reads 1 only when enable is clear and no write request is outstanding.
- R11: 0xFE0 reads {upper ID, lower ID} and 0xFE8 reads {cluster ID, core ID}, both taken from parameters. Any unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| tr_valid | input | 1 | Trace word valid |
| tr_data | input | 32 | Trace word |
| tr_ready | output | 1 | Trace word accepted when high together with tr_valid |
| wr_valid | output | 1 | Memory write request valid |
| wr_addr | output | 64 | Memory write byte address |
| wr_data | output | 32 | Memory write data |
| wr_ready | input | 1 | Memory accepts the request |
| irq | output | 1 | OR of the unmasked completion flags |

## Verification
The assertions assume three things about the inputs: the memory side eventually raises wr_ready, software does not change the buffer size while a buffer is partly filled, and the size is a nonzero multiple of four. The stimulus programs the size only while tracing is stopped or the ring sits at a buffer boundary, and it always uses 16 bytes. The only time wr_ready is held low is a bounded stall, and it is released before the run ends. Status clears are issued from the register bus only while no fill event is pending, so each clear-versus-set ordering checked by the bench is deterministic.

// File: rtl/trc_pkg.sv
package trc_pkg;
    localparam int NBUF  = 4;
    localparam int IDX_W = 2;
    localparam int CNT_W = 28;
    localparam int AW    = 64;
    localparam int DW    = 32;
    localparam int RAW   = 12;

    localparam logic [RAW-1:0] OFS_SIZE  = 12'h800;
    localparam logic [RAW-1:0] OFS_BASE0 = 12'h810;
    localparam logic [RAW-1:0] OFS_CTRL  = 12'h850;
    localparam logic [RAW-1:0] OFS_ISTAT = 12'h890;
    localparam logic [RAW-1:0] OFS_IMASK = 12'h894;
    localparam logic [RAW-1:0] OFS_WSTS  = 12'h8A0;
    localparam logic [RAW-1:0] OFS_TSTS  = 12'h8B0;
    localparam logic [RAW-1:0] OFS_RANGE = 12'hFE0;
    localparam logic [RAW-1:0] OFS_LOC   = 12'hFE8;

    typedef struct packed {
        logic [CNT_W-1:0]         size;
        logic [NBUF-1:0][AW-1:0]  base;
        logic                     en;
        logic                     dmarst;
        logic [NBUF-1:0]          mask;
    } cfg_state_t;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             wv;
        logic [AW-1:0]    waddr;
        logic [DW-1:0]    wdata;
    } fill_state_t;
endpackage

// File: rtl/trc_regs.sv
module trc_regs
    import trc_pkg::*;
#(
    parameter logic [CNT_W-1:0] DEF_BUF_BYTES = 28'h040_0000,
    parameter logic [15:0]      RANGE_UPPER   = 16'h0000,
    parameter logic [15:0]      RANGE_LOWER   = 16'h0000,
    parameter logic [15:0]      CORE_ID       = 16'h0000,
    parameter logic [15:0]      CLUSTER_ID    = 16'h0000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wen,
    input  logic [RAW-1:0]          reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    output logic [CNT_W-1:0]        cfg_size,
    output logic [NBUF-1:0][AW-1:0] cfg_base,
    output logic                    cfg_en,
    output logic                    cfg_dmarst,
    output logic [NBUF-1:0]         cfg_mask,
    output logic [NBUF-1:0]         stat_clr,
    input  logic [NBUF-1:0]         stat,
    input  logic [IDX_W-1:0]        cur_idx,
    input  logic [CNT_W-1:0]        cur_cnt,
    input  logic                    idle,
    input  logic                    ovf
);
    cfg_state_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        stat_clr = '0;
        if (reg_wen) begin
            if (reg_addr == OFS_SIZE)  r_d.size = reg_wdata[CNT_W-1:0];
            if (reg_addr == OFS_CTRL) begin
                r_d.en     = reg_wdata[0];
                r_d.dmarst = reg_wdata[1];
            end
            if (reg_addr == OFS_ISTAT) stat_clr = reg_wdata[NBUF-1:0];
            if (reg_addr == OFS_IMASK) r_d.mask = reg_wdata[NBUF-1:0];
            for (int i = 0; i < NBUF; i++) begin
                if (reg_addr == RAW'(OFS_BASE0 + 8*i))     r_d.base[i][31:0]  = reg_wdata;
                if (reg_addr == RAW'(OFS_BASE0 + 8*i + 4)) r_d.base[i][63:32] = reg_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.size <= DEF_BUF_BYTES;
            r_q.mask <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_SIZE:  reg_rdata = 32'(r_q.size);
            OFS_CTRL:  reg_rdata = {30'b0, r_q.dmarst, r_q.en};
            OFS_ISTAT: reg_rdata = 32'(stat);
            OFS_IMASK: reg_rdata = 32'(r_q.mask);
            OFS_WSTS:  reg_rdata = {2'b00, cur_idx, cur_cnt};
            OFS_TSTS:  reg_rdata = {30'b0, ovf, idle};
            OFS_RANGE: reg_rdata = {RANGE_UPPER, RANGE_LOWER};
            OFS_LOC:   reg_rdata = {CLUSTER_ID, CORE_ID};
            default:   reg_rdata = '0;
        endcase
        for (int i = 0; i < NBUF; i++) begin
            if (reg_addr == RAW'(OFS_BASE0 + 8*i))     reg_rdata = r_q.base[i][31:0];
            if (reg_addr == RAW'(OFS_BASE0 + 8*i + 4)) reg_rdata = r_q.base[i][63:32];
        end
    end

    assign cfg_size   = r_q.size;
    assign cfg_base   = r_q.base;
    assign cfg_en     = r_q.en;
    assign cfg_dmarst = r_q.dmarst;
    assign cfg_mask   = r_q.mask;

    // R9: a write to the control register lands in the enable bit on the next cycle
    a_r9_ctrl_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == OFS_CTRL) |=> (cfg_en == $past(reg_wdata[0])));
endmodule

// File: rtl/trc_irq.sv
module trc_irq
    import trc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NBUF-1:0] set_vec,
    input  logic [NBUF-1:0] clr_vec,
    input  logic [NBUF-1:0] mask,
    output logic [NBUF-1:0] stat,
    output logic            irq
);
    logic [NBUF-1:0] stat_d, stat_q;

    always_comb begin
        stat_d = (stat_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat = stat_q;
    assign irq  = |(stat_q & ~mask);

    // R4: at most one buffer completes per cycle
    a_r4_single_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_vec));

    for (genvar g = 0; g < NBUF; g++) begin : g_bit
        // R4: a flag rises only after a fill event for that buffer
        a_r4_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat_q[g]) |-> $past(set_vec[g]));
        // R5: a flag falls only after a write-1 clear of that bit
        a_r5_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(stat_q[g]) |-> $past(clr_vec[g]));
    end
endmodule

// File: rtl/trc_fill.sv
module trc_fill
    import trc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    dmarst,
    input  logic [CNT_W-1:0]        size,
    input  logic [NBUF-1:0][AW-1:0] base,
    input  logic [NBUF-1:0]         stat,
    input  logic                    tr_valid,
    input  logic [DW-1:0]           tr_data,
    output logic                    tr_ready,
    output logic                    wr_valid,
    output logic [AW-1:0]           wr_addr,
    output logic [DW-1:0]           wr_data,
    input  logic                    wr_ready,
    output logic [NBUF-1:0]         set_vec,
    output logic [IDX_W-1:0]        cur_idx,
    output logic [CNT_W-1:0]        cur_cnt,
    output logic                    ovf,
    output logic                    busy
);
    fill_state_t s_d, s_q;
    logic [CNT_W:0] nxt;
    logic           drop;

    assign tr_ready = en && !dmarst && !s_q.wv;
    assign drop     = (s_q.cnt == '0) && stat[s_q.idx];

    always_comb begin
        s_d     = s_q;
        set_vec = '0;
        nxt     = {1'b0, s_q.cnt} + (CNT_W+1)'(4);
        if (s_q.wv && wr_ready) begin
            s_d.wv = 1'b0;
            if (nxt >= {1'b0, size}) begin
                set_vec[s_q.idx] = 1'b1;
                s_d.idx          = s_q.idx + IDX_W'(1);
                s_d.cnt          = '0;
            end else begin
                s_d.cnt = nxt[CNT_W-1:0];
            end
        end
        if (tr_valid && tr_ready) begin
            if (drop) begin
                s_d.ovf = 1'b1;
            end else begin
                s_d.wv    = 1'b1;
                s_d.waddr = base[s_q.idx] + AW'(s_q.cnt);
                s_d.wdata = tr_data;
            end
        end
        if (dmarst && !s_q.wv) begin
            s_d.idx = '0;
            s_d.cnt = '0;
            s_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_valid = s_q.wv;
    assign wr_addr  = s_q.waddr;
    assign wr_data  = s_q.wdata;
    assign cur_idx  = s_q.idx;
    assign cur_cnt  = s_q.cnt;
    assign ovf      = s_q.ovf;
    assign busy     = s_q.wv;

    // R8: a stalled request holds address and data
    a_r8_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
    // R4: the index leaving the last buffer lands on buffer 0
    a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cur_idx) == IDX_W'(NBUF-1) && cur_idx != IDX_W'(NBUF-1)) |-> (cur_idx == '0));
    // R7: a word arriving on an uncleared buffer issues no write and flags overflow
    a_r7_drop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_valid && tr_ready && drop && !dmarst) |=> (!wr_valid && ovf));
    // R9: reset request with nothing outstanding returns the position to zero
    a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (dmarst && !wr_valid) |=> (cur_idx == '0 && cur_cnt == '0 && !ovf));
endmodule

// File: rtl/trace_ring_writer.sv
module trace_ring_writer
    import trc_pkg::*;
#(
    parameter logic [CNT_W-1:0] DEF_BUF_BYTES = 28'h040_0000,
    parameter logic [15:0]      RANGE_UPPER   = 16'h0000,
    parameter logic [15:0]      RANGE_LOWER   = 16'h0000,
    parameter logic [15:0]      CORE_ID       = 16'h0000,
    parameter logic [15:0]      CLUSTER_ID    = 16'h0000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wen,
    input  logic [RAW-1:0] reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    input  logic           tr_valid,
    input  logic [DW-1:0]  tr_data,
    output logic           tr_ready,
    output logic           wr_valid,
    output logic [AW-1:0]  wr_addr,
    output logic [DW-1:0]  wr_data,
    input  logic           wr_ready,
    output logic           irq
);
    logic [CNT_W-1:0]        cfg_size;
    logic [NBUF-1:0][AW-1:0] cfg_base;
    logic                    cfg_en, cfg_dmarst, ovf, busy, idle;
    logic [NBUF-1:0]         cfg_mask, stat_clr, stat, set_vec;
    logic [IDX_W-1:0]        cur_idx;
    logic [CNT_W-1:0]        cur_cnt;

    assign idle = !cfg_en && !busy;

    trc_regs #(
        .DEF_BUF_BYTES(DEF_BUF_BYTES), .RANGE_UPPER(RANGE_UPPER),
        .RANGE_LOWER(RANGE_LOWER), .CORE_ID(CORE_ID), .CLUSTER_ID(CLUSTER_ID)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_size(cfg_size),
        .cfg_base(cfg_base), .cfg_en(cfg_en), .cfg_dmarst(cfg_dmarst),
        .cfg_mask(cfg_mask), .stat_clr(stat_clr), .stat(stat),
        .cur_idx(cur_idx), .cur_cnt(cur_cnt), .idle(idle), .ovf(ovf)
    );

    trc_fill u_fill (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .dmarst(cfg_dmarst),
        .size(cfg_size), .base(cfg_base), .stat(stat), .tr_valid(tr_valid),
        .tr_data(tr_data), .tr_ready(tr_ready), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .set_vec(set_vec), .cur_idx(cur_idx), .cur_cnt(cur_cnt),
        .ovf(ovf), .busy(busy)
    );

    trc_irq u_irq (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(stat_clr),
        .mask(cfg_mask), .stat(stat), .irq(irq)
    );

    // R10: the engine never reports idle with a request on the write port
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !wr_valid);
endmodule

// File: tb/sim_trace_ring_writer.sv
`timescale 1ns/1ps
module sim_trace_ring_writer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tr_valid = 1'b0;
    logic [31:0] tr_data = '0;
    logic        tr_ready;
    logic        wr_valid;
    logic [63:0] wr_addr;
    logic [31:0] wr_data;
    logic        wr_ready = 1'b1;
    logic        irq;

    int nchk = 0;
    int nbad = 0;
    logic [63:0] log_a [0:63];
    logic [31:0] log_d [0:63];
    int nlog = 0;

    always #4 clk = ~clk;

    trace_ring_writer #(
        .RANGE_UPPER(16'h0710), .RANGE_LOWER(16'h0700),
        .CORE_ID(16'h0003), .CLUSTER_ID(16'h0001)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tr_valid(tr_valid),
        .tr_data(tr_data), .tr_ready(tr_ready), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready), .irq(irq)
    );

    always @(negedge clk) begin
        #2;
        if (rst_n && wr_valid && wr_ready && nlog < 64) begin
            log_a[nlog] = wr_addr;
            log_d[nlog] = wr_data;
            nlog = nlog + 1;
        end
    end

    function automatic logic [63:0] basev(int i);
        return {32'hA0 + 32'(i), 32'h0001_0000 * 32'(i + 1)};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wreg(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rreg(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic push(logic [31:0] d);
        @(negedge clk);
        tr_valid = 1'b1; tr_data = d;
        while (!tr_ready) @(negedge clk);
        @(negedge clk);
        tr_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 wr_valid", 64'(wr_valid), 64'd0);
        chk("R1 irq", 64'(irq), 64'd0);
        rreg(12'h8B0, v); chk("R1 tsts", 64'(v), 64'h1);
        rreg(12'h8A0, v); chk("R1 wsts", 64'(v), 64'h0);
        rreg(12'h894, v); chk("R1 mask", 64'(v), 64'hF);
        rreg(12'h800, v); chk("R1 size", 64'(v), 64'h40_0000);
        rreg(12'hFE0, v); chk("R11 range", 64'(v), 64'h0710_0700);
        rreg(12'hFE8, v); chk("R11 loc", 64'(v), 64'h0001_0003);
        rreg(12'h7FC, v); chk("R11 unmapped", 64'(v), 64'h0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wreg(12'h800, 32'd16);
        for (int i = 0; i < 4; i++) begin
            wreg(12'(12'h810 + 8*i), basev(i)[31:0]);
            wreg(12'(12'h814 + 8*i), basev(i)[63:32]);
        end
        rreg(12'h800, v); chk("R2 size", 64'(v), 64'd16);
        for (int i = 0; i < 4; i++) begin
            rreg(12'(12'h810 + 8*i), v); chk("R2 base lo", 64'(v), 64'(basev(i)[31:0]));
            rreg(12'(12'h814 + 8*i), v); chk("R2 base hi", 64'(v), 64'(basev(i)[63:32]));
        end
    endtask

    task automatic t_fill;
        logic [31:0] v;
        int n0, n1;
        wreg(12'h850, 32'h1);
        rreg(12'h8B0, v); chk("R10 enabled not idle", 64'(v), 64'h0);
        n0 = nlog;
        for (int k = 0; k < 4; k++) push(32'hC000_0000 + 32'(k));
        settle(3);
        chk("R3 count", 64'(nlog - n0), 64'd4);
        for (int k = 0; k < 4; k++) begin
            chk("R3 addr", log_a[n0 + k], basev(0) + 64'(4 * k));
            chk("R3 data", 64'(log_d[n0 + k]), 64'(32'hC000_0000 + 32'(k)));
        end
        rreg(12'h890, v); chk("R4 stat buf0", 64'(v), 64'h1);
        rreg(12'h8A0, v); chk("R4 wsts idx1", 64'(v), 64'h1000_0000);
        push(32'h11); push(32'h12); settle(3);
        rreg(12'h8A0, v); chk("R3 wsts partial", 64'(v), 64'h1000_0008);
        for (int k = 0; k < 10; k++) push(32'h20 + 32'(k));
        settle(3);
        rreg(12'h890, v); chk("R4 stat all", 64'(v), 64'hF);
        rreg(12'h8A0, v); chk("R4 wrap wsts", 64'(v), 64'h0);
        chk("R4 buf2 addr", log_a[n0 + 8], basev(2));
        chk("R4 buf3 addr", log_a[n0 + 12], basev(3));
        chk("R6 masked irq", 64'(irq), 64'd0);
        wreg(12'h894, 32'hE); #1;
        chk("R6 unmasked irq", 64'(irq), 64'd1);
        wreg(12'h890, 32'h0);
        rreg(12'h890, v); chk("R5 write0 no effect", 64'(v), 64'hF);
        wreg(12'h890, 32'h1);
        rreg(12'h890, v); chk("R5 w1c", 64'(v), 64'hE);
        chk("R6 irq after clear", 64'(irq), 64'd0);
        n1 = nlog;
        push(32'h55); settle(3);
        chk("R4 wrapped addr", log_a[n1], basev(0));
        push(32'h56); push(32'h57); push(32'h58); settle(3);
        rreg(12'h890, v); chk("R4 refill stat", 64'(v), 64'hF);
        n1 = nlog;
        push(32'h99); settle(3);
        chk("R7 dropped", 64'(nlog - n1), 64'd0);
        rreg(12'h8B0, v); chk("R7 overflow", 64'(v), 64'h2);
        rreg(12'h8A0, v); chk("R7 position kept", 64'(v), 64'h1000_0000);
    endtask

    task automatic t_dmarst;
        logic [31:0] v;
        int n1;
        wreg(12'h850, 32'h3); settle(2);
        rreg(12'h8A0, v); chk("R9 wsts zero", 64'(v), 64'h0);
        rreg(12'h8B0, v); chk("R9 ovf cleared", 64'(v), 64'h0);
        chk("R9 no accept", 64'(tr_ready), 64'd0);
        wreg(12'h850, 32'h1);
        wreg(12'h890, 32'hF);
        n1 = nlog;
        push(32'h77); settle(3);
        chk("R9 restart addr", log_a[n1], basev(0));
    endtask

    task automatic t_stall;
        logic [31:0] v;
        logic [63:0] a;
        int n1;
        @(negedge clk); wr_ready = 1'b0;
        n1 = nlog;
        push(32'hAB);
        settle(1); a = wr_addr;
        settle(3);
        chk("R8 valid held", 64'(wr_valid), 64'd1);
        chk("R8 addr held", wr_addr, a);
        chk("R8 addr", wr_addr, basev(0) + 64'd4);
        chk("R8 no accept", 64'(tr_ready), 64'd0);
        wreg(12'h850, 32'h0);
        rreg(12'h8B0, v); chk("R10 outstanding not idle", 64'(v), 64'h0);
        @(negedge clk); wr_ready = 1'b1;
        settle(2);
        rreg(12'h8B0, v); chk("R10 idle", 64'(v), 64'h1);
        chk("R8 delivered", 64'(nlog - n1), 64'd1);
        chk("R8 data", 64'(log_d[n1]), 64'hAB);
    endtask

    task automatic finish_run;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    endtask

    initial begin
        #100000;
        nchk++; nbad++;
        $display("FAIL watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(1);
        t_reset();
        t_regs();
        t_fill();
        t_dmarst();
        t_stall();
        finish_run();
    end
endmodule